// File: doc/BRIEF.md
# BCD Digit to Seven-Segment Decoder with Blanking Controls

This block takes one binary-coded decimal digit and produces the seven segment lines, a to g, for a single display position. Codes zero to nine light the matching numeral. The six codes above nine leave the position dark. Three control inputs sit above the plain lookup:

- A lamp-test input lights every segment.
- A blank input darkens the position.
- A zero-suppression input darkens the position when its digit is zero.

In a multi-digit display, the zero-suppression input and output are chained from the most significant digit downward. Each position tells the next lower one that it was suppressed. Leading zeros therefore vanish, and the first nonzero digit stops the chain.

The segment polarity is chosen by a parameter: high for common-cathode, low for common-anode. A second parameter either places the outputs behind one register stage, which has a synchronous active-high reset, or leaves the decoder fully combinational.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With no control input active, codes 0 to 9 produce these patterns (seg_o bit 0 = a up to bit 6 = g, 1 = lit): 0→7'h3F, 1→7'h06, 2→7'h5B, 3→7'h4F, 4→7'h66, 5→7'h6D, 6→7'h7D, 7→7'h07, 8→7'h7F, 9→7'h6F.
- R2: Codes 10 to 15 light no segment and keep zero_blank_o low, unless lamp test is active.
- R3: When lamp_test_i is high, all seven segments are lit and zero_blank_o is low, whatever the other inputs are.
- R4: When blank_i is high and lamp_test_i is low, no segment is lit and zero_blank_o is low, even if zero suppression would apply.
- R5: When zero_blank_i is high, the code is 0, and neither lamp_test_i nor blank_i is high, no segment is lit and zero_blank_o is high.
- R6: When zero_blank_i is high and the code is nonzero, the digit decodes as in R1 or R2, and zero_blank_o stays low.
- R7: zero_blank_o is high only in the R5 condition, so whenever it is high every segment is dark.
- R8: With ACTIVE_LOW=1, each segment line is the inverse of the active-high pattern; zero_blank_o keeps the same sense.
- R9: With REGISTERED=1, the outputs show the result for the inputs sampled at the previous rising clk edge. With REGISTERED=0, the outputs follow the inputs within the same cycle.
- R10: With REGISTERED=1, a cycle with rst high leaves every segment dark (at the chosen polarity) and zero_blank_o low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| digit_i | input | 4 | BCD code of the digit |
| lamp_test_i | input | 1 | Light all segments (highest priority) |
| blank_i | input | 1 | Darken the digit (second priority) |
| zero_blank_i | input | 1 | Suppress this digit if it is zero (from the more significant neighbour) |
| seg_o | output | 7 | Segment lines, bit 0 = a through bit 6 = g |
| zero_blank_o | output | 1 | This digit was suppressed as a leading zero (to the less significant neighbour) |

## Verification
The only state is the output register, so an error in it can show up only as a wrong pattern or a wrong chain bit. Such an error is visible one cycle after the inputs that caused it. A reset that fails to clear the register shows up as a lit segment in the first cycle after reset. A priority error shows up only for particular combinations of the controls, such as lamp test together with blank, or blank together with a suppressed zero. The stimulus therefore mixes these controls on purpose and covers all sixteen codes under each of them. The combinational, inverted-polarity variant is compared in the same cycle as its inputs, so any lag or any missing inversion is caught at once.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;

  // source that feeds the segment lines, in priority order
  typedef enum logic [1:0] {
    SRC_ALL_ON = 2'd0,
    SRC_DARK   = 2'd1,
    SRC_GLYPH  = 2'd2
  } seg_src_e;

endpackage

// File: rtl/seg_glyph_lut.sv
module seg_glyph_lut
  import seg_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] code_i,
  output seg_t               glyph_o,
  output logic               is_zero_o
);

  localparam int MAX_CODE = 9;

  always_comb begin
    glyph_o = '0;
    if (int'(code_i) <= MAX_CODE) begin
      unique case (code_i[3:0])
        4'd0: glyph_o = 7'b0111111;
        4'd1: glyph_o = 7'b0000110;
        4'd2: glyph_o = 7'b1011011;
        4'd3: glyph_o = 7'b1001111;
        4'd4: glyph_o = 7'b1100110;
        4'd5: glyph_o = 7'b1101101;
        4'd6: glyph_o = 7'b1111101;
        4'd7: glyph_o = 7'b0000111;
        4'd8: glyph_o = 7'b1111111;
        4'd9: glyph_o = 7'b1101111;
        default: glyph_o = '0;
      endcase
    end
  end

  assign is_zero_o = (code_i == '0);

endmodule

// File: rtl/seg_blank_arbiter.sv
module seg_blank_arbiter
  import seg_pkg::*;
(
  input  logic     lamp_test_i,
  input  logic     blank_i,
  input  logic     zero_blank_i,
  input  logic     is_zero_i,
  output seg_src_e src_o,
  output logic     zero_blank_o
);

  logic suppress;

  assign suppress = zero_blank_i & is_zero_i;

  always_comb begin
    src_o        = SRC_GLYPH;
    zero_blank_o = 1'b0;
    if (lamp_test_i) begin
      src_o = SRC_ALL_ON;
    end else if (blank_i) begin
      src_o = SRC_DARK;
    end else if (suppress) begin
      src_o        = SRC_DARK;
      zero_blank_o = 1'b1;
    end
  end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0,
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  seg_t lit_i,
  input  logic chain_i,
  output seg_t seg_o,
  output logic chain_o
);

  localparam seg_t POL_MASK = ACTIVE_LOW ? '1 : '0;

  seg_t drive;

  assign drive = lit_i ^ POL_MASK;

  generate
    if (REGISTERED) begin : g_reg
      seg_t seg_q;
      logic chain_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          seg_q   <= POL_MASK;
          chain_q <= 1'b0;
        end else begin
          seg_q   <= drive;
          chain_q <= chain_i;
        end
      end
      assign seg_o   = seg_q;
      assign chain_o = chain_q;
    end else begin : g_comb
      assign seg_o   = drive;
      assign chain_o = chain_i;
    end
  endgenerate

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import seg_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               lamp_test_i,
  input  logic               blank_i,
  input  logic               zero_blank_i,
  output logic [SEG_W-1:0]   seg_o,
  output logic               zero_blank_o
);

  seg_t     glyph;
  logic     is_zero;
  seg_src_e src;
  logic     chain;
  seg_t     lit;

  seg_glyph_lut #(.DIGIT_W(DIGIT_W)) u_lut (
    .code_i    (digit_i),
    .glyph_o   (glyph),
    .is_zero_o (is_zero)
  );

  seg_blank_arbiter u_arb (
    .lamp_test_i  (lamp_test_i),
    .blank_i      (blank_i),
    .zero_blank_i (zero_blank_i),
    .is_zero_i    (is_zero),
    .src_o        (src),
    .zero_blank_o (chain)
  );

  always_comb begin
    unique case (src)
      SRC_ALL_ON: lit = '1;
      SRC_DARK:   lit = '0;
      default:    lit = glyph;
    endcase
  end

  seg_out_stage #(.ACTIVE_LOW(ACTIVE_LOW), .REGISTERED(REGISTERED)) u_out (
    .clk     (clk),
    .rst     (rst),
    .lit_i   (lit),
    .chain_i (chain),
    .seg_o   (seg_o),
    .chain_o (zero_blank_o)
  );

endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk #(
  parameter int DIGIT_W    = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  parameter bit REGISTERED = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] digit_i,
  input logic               lamp_test_i,
  input logic               blank_i,
  input logic               zero_blank_i,
  input logic [6:0]         seg_o,
  input logic               zero_blank_o
);

  logic [6:0] lit;
  logic       over_nine;
  logic       sup_cond;

  assign lit       = ACTIVE_LOW ? ~seg_o : seg_o;
  assign over_nine = (int'(digit_i) > 9);
  assign sup_cond  = !lamp_test_i && !blank_i && zero_blank_i && (digit_i == '0);

  generate
    if (REGISTERED) begin : g_seq
      assert_lamp_all_on_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lamp_test_i)) |-> (lit == 7'h7F && !zero_blank_o));

      assert_blank_dark_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(lamp_test_i) && $past(blank_i)) |-> (lit == 7'h00 && !zero_blank_o));

      assert_zero_suppress_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sup_cond)) |-> (lit == 7'h00 && zero_blank_o));

      assert_invalid_dark_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(lamp_test_i) && $past(over_nine)) |-> (lit == 7'h00 && !zero_blank_o));

      assert_chain_only_when_suppressed_R7: assert property (@(posedge clk) disable iff (rst)
        zero_blank_o |-> ($past(sup_cond) && lit == 7'h00));

      assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lit == 7'h00 && !zero_blank_o));
    end else begin : g_comb
      always_comb begin
        if (!rst) begin
          if (lamp_test_i)
            assert_lamp_all_on_comb_R3: assert (lit == 7'h7F && !zero_blank_o);
          if (!lamp_test_i && blank_i)
            assert_blank_dark_comb_R4: assert (lit == 7'h00 && !zero_blank_o);
          if (sup_cond)
            assert_zero_suppress_comb_R5: assert (lit == 7'h00 && zero_blank_o);
          if (zero_blank_o)
            assert_chain_dark_comb_R7: assert (lit == 7'h00);
        end
      end
    end
  endgenerate

endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk #(
  .DIGIT_W(DIGIT_W), .ACTIVE_LOW(ACTIVE_LOW), .REGISTERED(REGISTERED)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .digit_i      (digit_i),
  .lamp_test_i  (lamp_test_i),
  .blank_i      (blank_i),
  .zero_blank_i (zero_blank_i),
  .seg_o        (seg_o),
  .zero_blank_o (zero_blank_o)
);

// File: tb/bcd_seg_decoder_test.sv
`timescale 1ns/1ps
module bcd_seg_decoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit = '0;
  logic       lt = 1'b0, bl = 1'b0, zbi = 1'b0;
  logic [6:0] seg_r, seg_c;
  logic       zbo_r, zbo_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] p_digit;
  logic       p_lt, p_bl, p_zbi;
  bit         have_prev = 1'b0;

  always #2.5 clk = ~clk;

  bcd_seg_decoder uut (
    .clk(clk), .rst(rst), .digit_i(digit), .lamp_test_i(lt), .blank_i(bl),
    .zero_blank_i(zbi), .seg_o(seg_r), .zero_blank_o(zbo_r)
  );

  bcd_seg_decoder #(.ACTIVE_LOW(1'b1), .REGISTERED(1'b0)) uut_inv (
    .clk(clk), .rst(rst), .digit_i(digit), .lamp_test_i(lt), .blank_i(bl),
    .zero_blank_i(zbi), .seg_o(seg_c), .zero_blank_o(zbo_c)
  );

  // expected {zero_blank_o, active-high segments}
  function automatic logic [7:0] model(input logic [3:0] d, input logic l, input logic b, input logic z);
    logic [6:0] g;
    case (d)
      4'd0: g = 7'h3F; 4'd1: g = 7'h06; 4'd2: g = 7'h5B; 4'd3: g = 7'h4F;
      4'd4: g = 7'h66; 4'd5: g = 7'h6D; 4'd6: g = 7'h7D; 4'd7: g = 7'h07;
      4'd8: g = 7'h7F; 4'd9: g = 7'h6F; default: g = 7'h00;
    endcase
    if (l) return {1'b0, 7'h7F};
    if (b) return {1'b0, 7'h00};
    if (z && d == 4'd0) return {1'b1, 7'h00};
    return {1'b0, g};
  endfunction

  function automatic string req_of(input logic [3:0] d, input logic l, input logic b, input logic z);
    if (l) return "R3";
    if (b) return "R4";
    if (z && d == 4'd0) return "R5/R7";
    if (d > 4'd9) return "R2";
    if (z) return "R6";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic l, input logic b, input logic z);
    @(negedge clk);
    if (have_prev)
      check({req_of(p_digit, p_lt, p_bl, p_zbi), " R9 registered"}, {zbo_r, seg_r},
            model(p_digit, p_lt, p_bl, p_zbi));
    digit = d; lt = l; bl = b; zbi = z;
    p_digit = d; p_lt = l; p_bl = b; p_zbi = z;
    have_prev = 1'b1;
    #1;
    check({req_of(d, l, b, z), " R8 R9 inverted comb"}, {zbo_c, ~seg_c}, model(d, l, b, z));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // reset with lamp test requested: registered outputs must still be dark
    lt = 1'b1; digit = 4'd8;
    repeat (3) @(negedge clk);
    check("R10 reset", {zbo_r, seg_r}, 8'h00);
    lt = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1/R2 every code plain, then with zero suppression (R6, R5)
    for (int i = 0; i < 16; i++) apply(4'(i), 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) apply(4'(i), 1'b0, 1'b0, 1'b1);
    // R3 over everything, R4 over suppression
    for (int i = 0; i < 16; i++) apply(4'(i), 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) apply(4'(i), 1'b0, 1'b1, i[0]);
    apply(4'd0, 1'b0, 1'b1, 1'b1);
    apply(4'd0, 1'b0, 1'b0, 1'b1);
    apply(4'd0, 1'b0, 1'b0, 1'b0);
    apply(4'd10, 1'b0, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [3:0] d;
      d = 4'($urandom_range(0, 15));
      apply(d, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
    end
    // mid-run reset: R10
    @(negedge clk);
    rst = 1'b1; lt = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset", {zbo_r, seg_r}, 8'h00);
    rst = 1'b0; lt = 1'b0; have_prev = 1'b0;
    apply(4'd7, 1'b0, 1'b0, 1'b0);
    apply(4'd7, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule